// File: doc/BRIEF.md
# Banked Register File Address Mapper

This block turns the register operand field of an instruction into a location in a small data memory. It holds the pointer register, which serves both as the indirect address and as the bank select. It also holds the general-purpose bytes: eight common bytes and four switchable banks of sixteen bytes each. A direct operand below 08h selects one of eight special-register slots. Operands 08h to 0Fh reach the common bytes. Operands 10h to 1Fh reach whichever bank the pointer's bits 6:5 currently select. Operand 00h is indirect: it uses the full 7-bit pointer as the target address.

Apart from the pointer, the special registers live outside the block. It reports an access to one of them on a one-hot select bus and a write pulse. It returns their read data through its own read multiplexer, taking it from a packed byte bus. Reads are combinational in the cycle of the strobe. Writes land at the next rising clock edge.

Top module: `rf_bank_mapper`

## Requirements
- R1: A direct operand k in 01h..07h with a strobe raises bit k of `sfr_sel` alone. A read returns byte k of `sfr_rd_bus` (bits 8k+7:8k), except for k = 4, which is the internal pointer. A write raises `sfr_wr`.
- R2: Direct operands 08h..0Fh map to storage index (operand - 8). The mapping does not change with the bank select.
- R3: Direct operands 10h..1Fh map to storage index 8 + 16*bank + operand[3:0]. Here bank is pointer bits 6:5, and `cur_bank` shows it.
- R4: Operand 00h uses the 7-bit pointer as the address. Targets 01h..07h are special slots and 08h..0Fh are common bytes. A target with bit 4 set goes to bank target[6:5], offset target[3:0].
- R5: An indirect access whose pointer is 00h reads as 00h. Its write changes no storage byte and raises no select.
- R6: Indirect targets 20h..2Fh, 40h..4Fh and 60h..6Fh are unimplemented. They read as 00h, give `ram_hit` = 0 and no select, and writes to them are dropped.
- R7: Reading the pointer (slot 4) returns {1, pointer[6:0]}. A write stores wr_data[6:0], and `cur_bank` follows from the next cycle.
- R8: After reset the pointer reads 80h (upper three bits 100), `cur_bank` is 0 and every storage byte is 00h.
- R9: With neither strobe high, `rd_data` is 00h, `sfr_sel` is 0 and `ram_hit` is 0.
- R10: A storage write is visible to a read in the following cycle. A read in the same cycle as a write to the same byte returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| op_addr | input | 5 | Direct operand address from the instruction |
| wr_data | input | 8 | Write data |
| sfr_rd_bus | input | 64 | Read data of the eight special slots, byte k for slot k |
| rd_data | output | 8 | Read data, combinational |
| sfr_sel | output | 8 | One-hot select of the special slot being accessed |
| sfr_wr | output | 1 | Write to a special slot this cycle |
| ram_hit | output | 1 | Access targets a storage byte |
| ram_idx | output | 7 | Flat storage index of the access |
| cur_bank | output | 2 | Bank currently switched into 10h..1Fh |

## Verification
The hardest cases to reach are the indirect ones: a pointer aimed at itself, at slot 00h, or into the holes between banks. Each one needs a pointer write through direct operand 04h first, and only then an access on operand 00h. The stimulus sets up these pointer values in sequence. It writes through operand 00h, for instance a write that moves the pointer into bank 3 through itself. A final sweep of all 72 bytes then shows that none of the dropped writes landed anywhere.

// File: rtl/rfmap_pkg.sv
package rfmap_pkg;
    localparam int DATA_W     = 8;
    localparam int DIR_AW     = 5;
    localparam int FULL_AW    = 7;
    localparam int SPEC_CNT   = 8;
    localparam int SPEC_W     = $clog2(SPEC_CNT);
    localparam int COMMON_CNT = 8;
    localparam int BANK_CNT   = 4;
    localparam int BANK_W     = $clog2(BANK_CNT);
    localparam int BANK_SZ    = 16;
    localparam int OFF_W      = $clog2(BANK_SZ);
    localparam int RAM_DEPTH  = COMMON_CNT + BANK_CNT * BANK_SZ;
    localparam int IDX_W      = $clog2(RAM_DEPTH);
    localparam int PTR_W      = FULL_AW;
    localparam int MSR_SLOT   = 4;

    typedef enum logic [1:0] {
        LOC_SPEC = 2'd0,
        LOC_RAM  = 2'd1,
        LOC_VOID = 2'd2
    } loc_kind_e;

    typedef struct packed {
        loc_kind_e          kind;
        logic [SPEC_W-1:0]  slot;
        logic [IDX_W-1:0]   idx;
    } loc_t;
endpackage

// File: rtl/rfmap_decode.sv
module rfmap_decode
    import rfmap_pkg::*;
(
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [DIR_AW-1:0]   op_addr,
    input  logic [PTR_W-1:0]    ptr,
    output loc_t                loc,
    output logic [SPEC_CNT-1:0] sfr_sel,
    output logic                sfr_wr,
    output logic                ram_hit,
    output logic                ram_we,
    output logic                msr_we,
    output logic                loc_void,
    output logic [IDX_W-1:0]    ram_idx
);
    logic               strobe;
    logic [FULL_AW-1:0] eff;

    // effective address: indirect, banked window or low direct range
    always_comb begin
        if (op_addr == '0) begin
            eff = ptr;
        end else if (op_addr[DIR_AW-1]) begin
            eff = {ptr[PTR_W-1 -: BANK_W], op_addr};
        end else begin
            eff = FULL_AW'(op_addr);
        end
    end

    // classify effective address
    always_comb begin
        loc.kind = LOC_VOID;
        loc.slot = '0;
        loc.idx  = '0;
        if (eff[FULL_AW-1:SPEC_W] == '0) begin
            loc.slot = eff[SPEC_W-1:0];
            if (eff[SPEC_W-1:0] != '0) begin
                loc.kind = LOC_SPEC;
            end
        end else if (eff[FULL_AW-1:OFF_W] == '0) begin
            loc.kind = LOC_RAM;
            loc.idx  = IDX_W'(eff[SPEC_W-1:0]);
        end else if (eff[OFF_W]) begin
            loc.kind = LOC_RAM;
            loc.idx  = IDX_W'(COMMON_CNT)
                     + IDX_W'({eff[FULL_AW-1 -: BANK_W], eff[OFF_W-1:0]});
        end
    end

    assign strobe = rd_en | wr_en;

    for (genvar k = 0; k < SPEC_CNT; k++) begin : g_sel
        assign sfr_sel[k] = strobe && (loc.kind == LOC_SPEC)
                            && (loc.slot == SPEC_W'(k));
    end

    assign sfr_wr   = wr_en && (loc.kind == LOC_SPEC);
    assign ram_hit  = strobe && (loc.kind == LOC_RAM);
    assign ram_we   = wr_en && (loc.kind == LOC_RAM);
    assign msr_we   = sfr_wr && (loc.slot == SPEC_W'(MSR_SLOT));
    assign loc_void = (loc.kind == LOC_VOID);
    assign ram_idx  = loc.idx;
endmodule

// File: rtl/rfmap_store.sv
module rfmap_store
    import rfmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ram_we,
    input  logic [IDX_W-1:0]  ram_idx,
    input  logic              msr_we,
    input  logic [DATA_W-1:0] wr_data,
    output logic [PTR_W-1:0]  ptr,
    output logic [DATA_W-1:0] ram_rdata
);
    typedef struct packed {
        logic [PTR_W-1:0]                   msr;
        logic [RAM_DEPTH-1:0][DATA_W-1:0]   mem;
    } st_t;

    st_t st_d, st_q;
    logic idx_ok;

    assign idx_ok = (ram_idx < IDX_W'(RAM_DEPTH));

    always_comb begin
        st_d = st_q;
        if (msr_we) begin
            st_d.msr = wr_data[PTR_W-1:0];
        end
        if (ram_we && idx_ok) begin
            st_d.mem[ram_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr       = st_q.msr;
    assign ram_rdata = idx_ok ? st_q.mem[ram_idx] : '0;
endmodule

// File: rtl/rfmap_rdmux.sv
module rfmap_rdmux
    import rfmap_pkg::*;
(
    input  logic                       rd_en,
    input  loc_t                       loc,
    input  logic [SPEC_CNT*DATA_W-1:0] sfr_rd_bus,
    input  logic [PTR_W-1:0]           ptr,
    input  logic [DATA_W-1:0]          ram_rdata,
    output logic [DATA_W-1:0]          rd_data
);
    logic [DATA_W-1:0] msr_view;

    assign msr_view = {1'b1, ptr};

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (loc.kind)
                LOC_SPEC: begin
                    if (loc.slot == SPEC_W'(MSR_SLOT)) begin
                        rd_data = msr_view;
                    end else begin
                        rd_data = sfr_rd_bus[loc.slot*DATA_W +: DATA_W];
                    end
                end
                LOC_RAM:  rd_data = ram_rdata;
                default:  rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/rf_bank_mapper.sv
module rf_bank_mapper
    import rfmap_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  logic                       wr_en,
    input  logic [DIR_AW-1:0]          op_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [SPEC_CNT*DATA_W-1:0] sfr_rd_bus,
    output logic [DATA_W-1:0]          rd_data,
    output logic [SPEC_CNT-1:0]        sfr_sel,
    output logic                       sfr_wr,
    output logic                       ram_hit,
    output logic [IDX_W-1:0]           ram_idx,
    output logic [BANK_W-1:0]          cur_bank
);
    loc_t              loc;
    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] ram_rdata;
    logic              ram_we;
    logic              msr_we;
    logic              loc_void;

    rfmap_decode u_decode (
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .op_addr  (op_addr),
        .ptr      (ptr),
        .loc      (loc),
        .sfr_sel  (sfr_sel),
        .sfr_wr   (sfr_wr),
        .ram_hit  (ram_hit),
        .ram_we   (ram_we),
        .msr_we   (msr_we),
        .loc_void (loc_void),
        .ram_idx  (ram_idx)
    );

    rfmap_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .ram_we    (ram_we),
        .ram_idx   (ram_idx),
        .msr_we    (msr_we),
        .wr_data   (wr_data),
        .ptr       (ptr),
        .ram_rdata (ram_rdata)
    );

    rfmap_rdmux u_rdmux (
        .rd_en      (rd_en),
        .loc        (loc),
        .sfr_rd_bus (sfr_rd_bus),
        .ptr        (ptr),
        .ram_rdata  (ram_rdata),
        .rd_data    (rd_data)
    );

    assign cur_bank = ptr[PTR_W-1 -: BANK_W];
endmodule

// File: rtl/rfmap_chk.sv
module rfmap_chk
    import rfmap_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rd_en,
    input logic                  wr_en,
    input logic [DATA_W-1:0]     wr_data,
    input logic [DATA_W-1:0]     rd_data,
    input logic [SPEC_CNT-1:0]   sfr_sel,
    input logic                  sfr_wr,
    input logic                  ram_hit,
    input logic [IDX_W-1:0]      ram_idx,
    input logic [BANK_W-1:0]     cur_bank,
    input logic                  loc_void
);
    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sfr_sel));

    assert_swr_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_wr |-> (wr_en && $countones(sfr_sel) == 1));

    assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_hit |-> (ram_idx < IDX_W'(RAM_DEPTH)));

    assert_void_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        loc_void |-> (rd_data == '0 && !ram_hit && sfr_sel == '0 && !sfr_wr));

    assert_msr_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sfr_sel[MSR_SLOT]) |-> rd_data[DATA_W-1]);

    assert_bank_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sfr_sel[MSR_SLOT]) |=> (cur_bank == $past(wr_data[PTR_W-1 -: BANK_W])));

    assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sfr_sel[MSR_SLOT]) |=> $stable(cur_bank));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en || wr_en) |-> (rd_data == '0 && sfr_sel == '0 && !ram_hit));
endmodule

bind rf_bank_mapper rfmap_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .sfr_sel  (sfr_sel),
    .sfr_wr   (sfr_wr),
    .ram_hit  (ram_hit),
    .ram_idx  (ram_idx),
    .cur_bank (cur_bank),
    .loc_void (loc_void)
);

// File: tb/rf_bank_mapper_tb_top.sv
module rf_bank_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  op_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [63:0] sfr_rd_bus;
    logic [7:0]  rd_data;
    logic [7:0]  sfr_sel;
    logic        sfr_wr;
    logic        ram_hit;
    logic [6:0]  ram_idx;
    logic [1:0]  cur_bank;

    typedef struct packed {
        logic [7:0] rd;
        logic [7:0] sel;
        logic       hit;
        logic [6:0] idx;
        logic       swr;
        logic [1:0] bank;
    } item_t;

    item_t  q[$];
    string  tq[$];
    int     vectors = 0;
    int     fails = 0;
    bit     finished = 1'b0;
    logic [7:0] mem_m [72];
    logic [6:0] msr_m = '0;

    always #2 clk = ~clk;

    rf_bank_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .op_addr(op_addr), .wr_data(wr_data), .sfr_rd_bus(sfr_rd_bus),
        .rd_data(rd_data), .sfr_sel(sfr_sel), .sfr_wr(sfr_wr),
        .ram_hit(ram_hit), .ram_idx(ram_idx), .cur_bank(cur_bank)
    );

    // expected location from requirements R1..R6 (kind 0 special, 1 storage, 2 void)
    task automatic classify(input logic [4:0] a, output int kind, output int k, output int idx);
        logic [6:0] e;
        if (a == 5'd0)  e = msr_m;
        else if (a[4])  e = {msr_m[6:5], a};
        else            e = {2'b00, a};
        kind = 2; k = 0; idx = 0;
        if (e < 7'd8) begin
            k = int'(e);
            kind = (e == 7'd0) ? 2 : 0;
        end else if (e < 7'd16) begin
            kind = 1; idx = int'(e) - 8;
        end else if (e[4]) begin
            kind = 1; idx = 8 + 16 * int'(e[6:5]) + int'(e[3:0]);
        end
    endtask

    task automatic access(input logic r, input logic w, input logic [4:0] a,
                          input logic [7:0] d, input string tag);
        item_t it;
        int kind, k, idx;
        @(posedge clk); #1;
        rd_en = r; wr_en = w; op_addr = a; wr_data = d;
        classify(a, kind, k, idx);
        it.bank = msr_m[6:5];
        it.rd   = '0;
        it.sel  = '0;
        it.hit  = 1'b0;
        it.idx  = 7'(idx);
        it.swr  = 1'b0;
        if (r || w) begin
            if (kind == 0) begin
                it.sel = 8'(1 << k);
                it.swr = w;
                if (r) it.rd = (k == 4) ? {1'b1, msr_m} : sfr_rd_bus[k*8 +: 8];
            end else if (kind == 1) begin
                it.hit = 1'b1;
                if (r) it.rd = mem_m[idx];
            end
        end
        q.push_back(it);
        tq.push_back(tag);
        if (w) begin
            if (kind == 1) mem_m[idx] = d;
            if (kind == 0 && k == 4) msr_m = d[6:0];
        end
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        access(1'b1, 1'b0, a, 8'h00, tag);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d, input string tag);
        access(1'b0, 1'b1, a, d, tag);
    endtask

    // monitor: compares in the middle of each cycle
    initial begin
        item_t it;
        string tg;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                it = q.pop_front();
                tg = tq.pop_front();
                vectors++;
                if (rd_data !== it.rd) begin
                    fails++;
                    $display("FAIL %s rd_data got %02h exp %02h", tg, rd_data, it.rd);
                end
                if (sfr_sel !== it.sel) begin
                    fails++;
                    $display("FAIL %s sfr_sel got %02h exp %02h", tg, sfr_sel, it.sel);
                end
                if (ram_hit !== it.hit) begin
                    fails++;
                    $display("FAIL %s ram_hit got %0b exp %0b", tg, ram_hit, it.hit);
                end
                if (it.hit && ram_idx !== it.idx) begin
                    fails++;
                    $display("FAIL %s ram_idx got %0d exp %0d", tg, ram_idx, it.idx);
                end
                if (sfr_wr !== it.swr) begin
                    fails++;
                    $display("FAIL %s sfr_wr got %0b exp %0b", tg, sfr_wr, it.swr);
                end
                if (cur_bank !== it.bank) begin
                    fails++;
                    $display("FAIL %s cur_bank got %0d exp %0d", tg, cur_bank, it.bank);
                end
            end
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog expired with %0d items pending", q.size());
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) sfr_rd_bus[k*8 +: 8] = 8'hA0 | 8'(k);
        for (int i = 0; i < 72; i++) mem_m[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8: reset values
        rd(5'h04, "R8 pointer after reset");
        for (int i = 8; i < 32; i++) rd(5'(i), "R8 storage clear after reset");

        // R9: no strobe
        access(1'b0, 1'b0, 5'h04, 8'h55, "R9 idle pointer");
        access(1'b0, 1'b0, 5'h09, 8'h55, "R9 idle storage");

        // R1: special slots
        for (int k = 1; k < 8; k++) rd(5'(k), "R1 special read");
        wr(5'h03, 8'h3C, "R1 special write");
        wr(5'h06, 8'h11, "R1 special write");

        // R2: common bytes
        for (int i = 8; i < 16; i++) wr(5'(i), 8'h10 + 8'(i), "R2 common write");

        // R3: banks, with common bytes seen from each bank
        for (int b = 0; b < 4; b++) begin
            wr(5'h04, 8'(b << 5), "R7 bank select write");
            for (int o = 0; o < 16; o++) wr(5'(16 + o), 8'({b[1:0], o[3:0]}) ^ 8'h5A, "R3 bank write");
            rd(5'h08, "R2 common from bank");
            rd(5'h0F, "R2 common from bank");
        end
        for (int b = 0; b < 4; b++) begin
            wr(5'h04, 8'(b << 5), "R7 bank select write");
            for (int o = 0; o < 16; o++) rd(5'(16 + o), "R3 bank read");
        end

        // R4: indirect access
        wr(5'h04, 8'h35, "R4 pointer to bank1 offset5");
        rd(5'h00, "R4 indirect bank read");
        wr(5'h00, 8'hC3, "R4 indirect bank write");
        rd(5'h15, "R4 direct view of indirect write");
        wr(5'h04, 8'h0B, "R4 pointer to common");
        rd(5'h00, "R4 indirect common read");
        wr(5'h04, 8'h06, "R4 pointer to special");
        rd(5'h00, "R4 indirect special read");
        wr(5'h00, 8'h77, "R4 indirect special write");
        wr(5'h04, 8'h04, "R4 pointer to itself");
        rd(5'h00, "R4 indirect pointer read");
        wr(5'h00, 8'h7F, "R4 indirect pointer write");
        rd(5'h04, "R7 pointer after indirect write");
        rd(5'h1F, "R3 bank3 after indirect switch");

        // R5: pointer at 00
        wr(5'h04, 8'h00, "R5 pointer to zero");
        rd(5'h00, "R5 null read");
        wr(5'h00, 8'hFF, "R5 null write");
        rd(5'h00, "R5 null read after write");

        // R6: holes between banks
        wr(5'h04, 8'h25, "R6 pointer hole");
        rd(5'h00, "R6 hole read");
        wr(5'h00, 8'hEE, "R6 hole write");
        wr(5'h04, 8'h4A, "R6 pointer hole");
        wr(5'h00, 8'hDD, "R6 hole write");
        rd(5'h00, "R6 hole read");
        wr(5'h04, 8'h6F, "R6 pointer hole");
        wr(5'h00, 8'hCC, "R6 hole write");
        rd(5'h00, "R6 hole read");

        // R7: pointer readback
        wr(5'h04, 8'hFF, "R7 pointer write");
        rd(5'h04, "R7 pointer read");
        wr(5'h04, 8'h12, "R7 pointer write");
        rd(5'h04, "R7 pointer read top bit");

        // R10: same-cycle read and write
        access(1'b1, 1'b1, 5'h0A, 8'hB4, "R10 read during write");
        rd(5'h0A, "R10 read after write");

        // final sweep: nothing dropped leaked into storage (R5, R6)
        for (int b = 0; b < 4; b++) begin
            wr(5'h04, 8'(b << 5), "R7 bank select write");
            for (int o = 0; o < 16; o++) rd(5'(16 + o), "R6 sweep bank");
        end
        for (int i = 8; i < 16; i++) rd(5'(i), "R5 sweep common");

        @(posedge clk); #1;
        rd_en = 1'b0; wr_en = 1'b0;
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule